// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer with Standby Wakeup

This block is an up-counting timer whose counter and control register are reached through a 16-bit write port. Each register has its own key, and a write changes a register only when the upper half of the data carries that key. Software can therefore not change the timer by accident through a stray store. A prescaler divides the module clock by one of eight ratios. In normal operation the counter runs while the enable bit is set. On overflow the block either flags an interval event and raises an interrupt, or flags a watchdog event and emits a one-cycle reset pulse.

The block also times the settling of the clock when the system leaves standby. While the system reports standby, a wake event starts the count even if the enable bit is clear. When this recovery count overflows, the block pulses a clock-resume output and leaves the flags untouched. The counter then carries on from zero. If the standby-enable input is still set when the count reaches the midpoint, the block requests standby again and freezes. Only the power-on reset releases that state. If the standby-enable input is cleared at any point during the recovery count, the counter stops and the block returns to idle.

Top module: `kwdt`

## Requirements
- R1: A write with `wr_sel`=0 loads `wr_data[7:0]` into the counter only when `wr_data[15:8]` is 8'h5A. Any other upper byte leaves the counter unchanged.
- R2: A write with `wr_sel`=1 loads `wr_data[7:0]` into the control register only when `wr_data[15:8]` is 8'hA5. Any other upper byte leaves the register unchanged. Control bit positions: [2:0] clock select, [4] interval flag, [5] run enable, [6] mode (1 = watchdog, 0 = interval), [7] watchdog flag.
- R3: `rd_data` returns the counter when `rd_sel`=0 and the control register when `rd_sel`=1, with bits 15:8 zero. Both registers are zero after reset.
- R4: Outside recovery, the counter advances only while the run-enable bit is 1 and `in_stby` is 0. It advances by one every N clocks, where clock-select codes 0..7 give N = 1, 4, 16, 32, 64, 256, 1024 and 4096. A control write restarts the prescaler, so the first increment happens N clocks after the write edge.
- R5: In interval mode, a normal-mode increment from 8'hFF to 8'h00 sets bit 4. `irq` equals bit 4.
- R6: In watchdog mode, a normal-mode overflow sets bit 7 and drives `wdt_rst` high for exactly one cycle, in the cycle after the overflow edge.
- R7: While idle with `in_stby`=1 and `stby_en`=1, a cycle with `wake_req`=1 starts the recovery count at the current counter value, regardless of the run-enable bit.
- R8: A recovery overflow drives `clk_resume` high for one cycle, leaves control bits 7 and 4 unchanged, and the count continues from 8'h00.
- R9: After a recovery overflow, if `stby_en` is 1 when the counter reaches 8'h80, `stby_req` goes high and the counter stops at 8'h80. Both hold until `rst_n` is asserted.
- R10: If `stby_en` is 0 at any point during recovery counting, before or after the overflow, the counter stops and the block returns to idle without asserting `stby_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 control |
| wr_data | input | 16 | Key in [15:8], value in [7:0] |
| rd_sel | input | 1 | Read source: 0 counter, 1 control |
| rd_data | output | 16 | Selected register, upper byte zero |
| in_stby | input | 1 | System is in standby |
| stby_en | input | 1 | Standby enable from the power controller |
| wake_req | input | 1 | Wake event (edge or interrupt request) |
| irq | output | 1 | Interval interrupt, equal to control bit 4 |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| clk_resume | output | 1 | One-cycle pulse ending clock settling |
| stby_req | output | 1 | Re-entry into standby, held until reset |

## Verification
The hardest situation to reach from the ports is the midpoint re-entry into standby. It comes only after a wake event, a full recovery overflow and a second half-count, all with the standby-enable input held high. The stimulus gets there quickly by picking the divide-by-one clock, preloading the counter just below the top and then pulsing the wake input. It then waits on `clk_resume` and `stby_req`, checks the frozen count, and confirms that only the reset line releases it. Two further runs drop the standby-enable input, once before the overflow and once after it, to exercise both exits back to idle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RECOV = 2'd1,
      ST_POST  = 2'd2,
      ST_HALT  = 2'd3
   } kwdt_state_e;

   // control register bit positions
   localparam int CTL_IOVF = 4;
   localparam int CTL_TME  = 5;
   localparam int CTL_MODE = 6;
   localparam int CTL_WOVF = 7;
   localparam int CTL_BITS = 8;
   localparam int MAX_SHIFT = 12;

   // log2 of the prescaler ratio for each clock-select code
   function automatic int unsigned div_shift(input logic [2:0] code);
      case (code)
         3'd0:    return 0;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 5;
         3'd4:    return 6;
         3'd5:    return 8;
         3'd6:    return 10;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/kwdt_keydec.sv
module kwdt_keydec #(
   parameter int          DW      = 16,
   parameter int unsigned KEY_CNT = 'h5A,
   parameter int unsigned KEY_CTL = 'hA5,
   localparam int         HW      = DW / 2
) (
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [DW-1:0] wr_data,
   output logic          cnt_ld,
   output logic          ctl_ld,
   output logic [HW-1:0] ld_val
);

   if (DW % 2 != 0) begin : g_bad_dw
      $error("kwdt_keydec: DW must be even");
   end

   logic [HW-1:0] key_hi;

   always_comb begin
      key_hi = wr_data[DW-1:HW];
      ld_val = wr_data[HW-1:0];
      cnt_ld = wr_en && !wr_sel && (key_hi == HW'(KEY_CNT));
      ctl_ld = wr_en &&  wr_sel && (key_hi == HW'(KEY_CTL));
   end

endmodule

// File: rtl/kwdt_presc.sv
module kwdt_presc
   import kwdt_pkg::*;
#(
   parameter int PW = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       run,
   input  logic [2:0] sel,
   output logic       tick
);

   if (PW < MAX_SHIFT) begin : g_bad_pw
      $error("kwdt_presc: PW too small for the largest ratio");
   end

   logic [PW-1:0] pre_q;
   logic [PW-1:0] lim;

   always_comb begin
      lim  = PW'((32'd1 << div_shift(sel)) - 32'd1);
      tick = run && (pre_q == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pre_q <= '0;
      else if (clr || !run || tick)  pre_q <= '0;
      else                           pre_q <= pre_q + 1'b1;
   end

   AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> pre_q <= lim) else $error("prescaler past limit");   // R4

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
   import kwdt_pkg::*;
#(
   parameter int HW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_ld,
   input  logic          ctl_ld,
   input  logic [HW-1:0] ld_val,
   input  logic          in_stby,
   input  logic          stby_en,
   input  logic          wake_req,
   input  logic          tick,
   output logic          run,
   output logic [HW-1:0] cnt_q,
   output logic [HW-1:0] ctl_q,
   output logic          wdt_rst,
   output logic          clk_resume,
   output logic          stby_req
);

   if (HW < CTL_BITS) begin : g_bad_hw
      $error("kwdt_core: register half must hold the control byte");
   end

   localparam logic [HW-1:0] MID = HW'(1) << (HW - 1);
   localparam logic [HW-1:0] TOP = '1;

   kwdt_state_e st_q, st_d;
   logic at_top, at_mid, wrap, nrm_ovf, rec_ovf;

   always_comb begin
      at_top  = (cnt_q == TOP);
      at_mid  = (cnt_q == MID);
      run     = (st_q == ST_IDLE && ctl_q[CTL_TME] && !in_stby)
             || (stby_en && (st_q == ST_RECOV || (st_q == ST_POST && !at_mid)));
      wrap    = tick && at_top;
      nrm_ovf = wrap && (st_q == ST_IDLE);
      rec_ovf = wrap && (st_q == ST_RECOV);
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (in_stby && stby_en && wake_req) st_d = ST_RECOV;
         ST_RECOV: if (!stby_en) st_d = ST_IDLE;
                   else if (rec_ovf) st_d = ST_POST;
         ST_POST:  if (!stby_en) st_d = ST_IDLE;
                   else if (at_mid) st_d = ST_HALT;
         default:  st_d = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         ctl_q      <= '0;
         wdt_rst    <= 1'b0;
         clk_resume <= 1'b0;
      end else begin
         st_q       <= st_d;
         wdt_rst    <= nrm_ovf && ctl_q[CTL_MODE];
         clk_resume <= rec_ovf;
         if (cnt_ld)    cnt_q <= ld_val;
         else if (tick) cnt_q <= cnt_q + 1'b1;
         if (ctl_ld) begin
            ctl_q <= ld_val;
         end else if (nrm_ovf) begin
            if (ctl_q[CTL_MODE]) ctl_q[CTL_WOVF] <= 1'b1;
            else                 ctl_q[CTL_IOVF] <= 1'b1;
         end
      end
   end

   assign stby_req = (st_q == ST_HALT);

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_ld && !tick) |=> $stable(cnt_q)) else $error("counter moved");   // R1
   AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !ctl_q[CTL_TME]) |-> !tick) else $error("tick while off");   // R4
   AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> !wdt_rst) else $error("reset pulse too long");   // R6
   AST_RESUME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_resume && !$past(ctl_ld)) |-> (ctl_q[CTL_WOVF] == $past(ctl_q[CTL_WOVF])
                                        && ctl_q[CTL_IOVF] == $past(ctl_q[CTL_IOVF])))
      else $error("flag set on resume");   // R8
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stby_req |=> stby_req) else $error("standby request dropped");   // R9
   AST_HALT_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stby_req) |-> cnt_q == MID) else $error("halt off midpoint");   // R9

endmodule

// File: rtl/kwdt.sv
module kwdt #(
   parameter int          DW      = 16,
   parameter int unsigned KEY_CNT = 'h5A,
   parameter int unsigned KEY_CTL = 'hA5,
   parameter int          PW      = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_sel,
   output logic [DW-1:0] rd_data,
   input  logic          in_stby,
   input  logic          stby_en,
   input  logic          wake_req,
   output logic          irq,
   output logic          wdt_rst,
   output logic          clk_resume,
   output logic          stby_req
);

   localparam int HW = DW / 2;

   logic          cnt_ld, ctl_ld, run, tick;
   logic [HW-1:0] ld_val, cnt_q, ctl_q;

   kwdt_keydec #(.DW(DW), .KEY_CNT(KEY_CNT), .KEY_CTL(KEY_CTL)) u_keydec (
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .cnt_ld(cnt_ld), .ctl_ld(ctl_ld), .ld_val(ld_val)
   );

   kwdt_presc #(.PW(PW)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(ctl_ld), .run(run),
      .sel(ctl_q[2:0]), .tick(tick)
   );

   kwdt_core #(.HW(HW)) u_core (
      .clk(clk), .rst_n(rst_n), .cnt_ld(cnt_ld), .ctl_ld(ctl_ld),
      .ld_val(ld_val), .in_stby(in_stby), .stby_en(stby_en),
      .wake_req(wake_req), .tick(tick), .run(run), .cnt_q(cnt_q),
      .ctl_q(ctl_q), .wdt_rst(wdt_rst), .clk_resume(clk_resume),
      .stby_req(stby_req)
   );

   always_comb begin
      rd_data = {{HW{1'b0}}, (rd_sel ? ctl_q : cnt_q)};
      irq     = ctl_q[kwdt_pkg::CTL_IOVF];
   end

endmodule

// File: tb/test_kwdt.sv
`timescale 1ns/1ps
module test_kwdt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        in_stby = 1'b0, stby_en = 1'b0, wake_req = 1'b0;
   logic [15:0] rd_data;
   logic        irq, wdt_rst, clk_resume, stby_req;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   kwdt i_kwdt (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .in_stby(in_stby), .stby_en(stby_en), .wake_req(wake_req),
      .irq(irq), .wdt_rst(wdt_rst), .clk_resume(clk_resume),
      .stby_req(stby_req)
   );

   // ---------------- behavioural reference ----------------
   int       m_st, m_cnt, m_pre, m_div;   // m_st: 0 idle, 1 recovering, 2 after resume, 3 halted
   bit [7:0] m_ctl;
   bit       m_rst, m_res, m_run, m_tick, m_wrap, k_c, k_t;
   int       n_st;

   function automatic int ratio(input bit [2:0] c);
      int r [8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
      return r[c];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_pre = 0; m_ctl = 0; m_rst = 0; m_res = 0;
      end else begin
         m_div  = ratio(m_ctl[2:0]);
         m_run  = (m_st == 0 && m_ctl[5] && !in_stby)
               || (stby_en && (m_st == 1 || (m_st == 2 && m_cnt != 128)));
         m_tick = m_run && (m_pre == m_div - 1);
         m_wrap = m_tick && (m_cnt == 255);
         k_c    = wr_en && !wr_sel && wr_data[15:8] == 8'h5A;
         k_t    = wr_en &&  wr_sel && wr_data[15:8] == 8'hA5;
         n_st   = m_st;
         if (m_st == 0 && in_stby && stby_en && wake_req) n_st = 1;
         else if (m_st == 1) n_st = !stby_en ? 0 : (m_wrap ? 2 : 1);
         else if (m_st == 2) n_st = !stby_en ? 0 : (m_cnt == 128 ? 3 : 2);
         m_rst = m_wrap && m_st == 0 && m_ctl[6];
         m_res = m_wrap && m_st == 1;
         if (k_t) m_ctl = wr_data[7:0];
         else if (m_wrap && m_st == 0) begin
            if (m_ctl[6]) m_ctl[7] = 1'b1;
            else          m_ctl[4] = 1'b1;
         end
         if (k_c) m_cnt = wr_data[7:0];
         else if (m_tick) m_cnt = (m_cnt + 1) % 256;
         m_pre = (k_t || !m_run || m_tick) ? 0 : m_pre + 1;
         m_st  = n_st;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("MODEL rd_data", rd_data, rd_sel ? {8'h0, m_ctl} : 16'(m_cnt));
         chk("MODEL irq R5", irq, m_ctl[4]);
         chk("MODEL wdt_rst R6", wdt_rst, m_rst);
         chk("MODEL clk_resume R8", clk_resume, m_res);
         chk("MODEL stby_req R9", stby_req, m_st == 3);
      end
   end

   task automatic wr(input bit sel, input bit [7:0] key, input bit [7:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = {key, val};
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input bit sel, input logic [15:0] exp, input string tag);
      @(negedge clk);
      rd_sel = sel;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic pulse_wake();
      @(negedge clk); wake_req = 1'b1;
      @(negedge clk); wake_req = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 190000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      bit          seen;
      int          pulses;
      logic [15:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd_chk(0, 16'h0000, "R3 counter after reset");
      rd_chk(1, 16'h0000, "R3 control after reset");
      chk("R9 no request after reset", stby_req, 1'b0);

      wr(0, 8'h5A, 8'h37);
      rd_chk(0, 16'h0037, "R1 keyed counter load");
      wr(0, 8'h5B, 8'h11);
      rd_chk(0, 16'h0037, "R1 wrong key ignored");
      wr(0, 8'hA5, 8'h11);
      rd_chk(0, 16'h0037, "R1 control key on counter ignored");

      wr(1, 8'h5A, 8'h07);
      rd_chk(1, 16'h0000, "R2 wrong key ignored");
      wr(1, 8'hA5, 8'h03);
      rd_chk(1, 16'h0003, "R2 keyed control load");
      repeat (10) @(negedge clk);
      rd_chk(0, 16'h0037, "R4 no count with enable clear");

      for (int c = 0; c < 8; c++) begin
         wr(1, 8'hA5, 8'h00);
         wr(0, 8'h5A, 8'h00);
         wr(1, 8'hA5, 8'(8'h20 | c));
         repeat (3 * ratio(3'(c)) - 1) @(negedge clk);
         rd_chk(0, 16'h0003, $sformatf("R4 divide code %0d", c));
      end

      wr(1, 8'hA5, 8'h00);
      wr(0, 8'h5A, 8'h10);
      @(negedge clk); in_stby = 1'b1;
      wr(1, 8'hA5, 8'h20);
      repeat (20) @(negedge clk);
      rd_chk(0, 16'h0010, "R4 no count in standby");
      wr(1, 8'hA5, 8'h00);
      @(negedge clk); in_stby = 1'b0;

      wr(0, 8'h5A, 8'hFD);
      wr(1, 8'hA5, 8'h20);
      repeat (6) @(negedge clk);
      #1 chk("R5 interrupt raised", irq, 1'b1);
      rd_chk(1, 16'h0030, "R5 interval flag set");
      wr(1, 8'hA5, 8'h00);
      #1 chk("R5 interrupt follows flag", irq, 1'b0);

      wr(0, 8'h5A, 8'hFE);
      wr(1, 8'hA5, 8'h60);
      pulses = 0;
      repeat (8) begin
         @(negedge clk); #1;
         if (wdt_rst) pulses++;
      end
      chk("R6 single reset pulse", pulses, 1);
      rd_chk(1, 16'h00E0, "R6 watchdog flag set");
      wr(1, 8'hA5, 8'h00);

      // recovery, resume and re-standby at midpoint
      wr(0, 8'h5A, 8'hF0);
      @(negedge clk); in_stby = 1'b1; stby_en = 1'b1;
      repeat (5) @(negedge clk);
      rd_chk(0, 16'h00F0, "R7 idle until wake");
      pulse_wake();
      repeat (3) @(negedge clk);
      #1 chk("R7 wake starts count", rd_data > 16'h00F0, 1'b1);
      seen = 0;
      for (int i = 0; i < 100 && !seen; i++) begin
         @(negedge clk); #1;
         if (clk_resume) seen = 1;
      end
      chk("R8 resume pulse", seen, 1'b1);
      chk("R8 count restarts at zero", rd_data, 16'h0000);
      rd_chk(1, 16'h0000, "R8 no flag on resume");
      rd_sel = 1'b0;
      seen = 0;
      for (int i = 0; i < 400 && !seen; i++) begin
         @(negedge clk); #1;
         if (stby_req) seen = 1;
      end
      chk("R9 standby request", seen, 1'b1);
      rd_chk(0, 16'h0080, "R9 stops at midpoint");
      repeat (20) @(negedge clk);
      rd_chk(0, 16'h0080, "R9 count frozen");
      @(negedge clk); stby_en = 1'b0;
      repeat (5) @(negedge clk);
      #1 chk("R9 only reset releases", stby_req, 1'b1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1 chk("R9 reset releases request", stby_req, 1'b0);

      // leave recovery before overflow
      wr(0, 8'h5A, 8'hF0);
      @(negedge clk); stby_en = 1'b1;
      pulse_wake();
      repeat (5) @(negedge clk);
      stby_en = 1'b0;
      repeat (3) @(negedge clk);
      #1 snap = rd_data;
      repeat (30) @(negedge clk);
      #1 chk("R10 stop before overflow", rd_data, snap);

      // leave after resume
      @(negedge clk); stby_en = 1'b1;
      pulse_wake();
      seen = 0;
      for (int i = 0; i < 100 && !seen; i++) begin
         @(negedge clk); #1;
         if (clk_resume) seen = 1;
      end
      chk("R10 resume reached", seen, 1'b1);
      repeat (10) @(negedge clk);
      stby_en = 1'b0;
      repeat (3) @(negedge clk);
      #1 snap = rd_data;
      repeat (200) @(negedge clk);
      #1 chk("R10 stop after resume", rd_data, snap);
      chk("R10 no standby request", stby_req, 1'b0);

      @(negedge clk); in_stby = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule